// File: doc/BRIEF.md
# Partial Distortion Bias Chain

This block sits between a codebook distance array and a winner-search comparator chain in a competitive-learning vector quantizer. It holds one unit per codeword column. Every unit keeps a running partial distortion for its codeword. It adds a right-shifted copy of that value to the column's incoming distortion. It passes both the biased distortion and the plain distortion on to the comparators. Codewords that have already collected a large error therefore look further away, and lose more often.

When a competition is decided, a winner token (codeword index plus the winner's distortion) enters the leftmost unit. It travels one unit per cycle. The unit whose index matches adds the distortion to its partial distortion, scaled by 49/64. That factor is (1 - 1/8)^2 and allows for the codeword not yet having moved.

A shift amount grows by one after a fixed number of sweep-end strobes, so the bias fades as learning proceeds. A synchronous clear restarts learning. Distortion vectors for all columns arrive together on a valid/ready stream and leave on one registered valid/ready stream.

Top module: `pdb_chain`

## Requirements
- R1: After reset or a cycle with `clr` high, every partial distortion and the shift amount are zero, so each biased output equals its plain distortion.
- R2: For an accepted input vector, column k's `raw_out` slice (bits `[k*D_W +: D_W]`) equals its input, and its `biased_out` slice (bits `[k*PD_W +: PD_W]`) equals d + (pd_k >> shift). Both are registered and appear one cycle after acceptance.
- R3: A winner token presented with `win_valid` at edge E adds floor(49*d/64) to the partial distortion of unit `win_id` by edge E+k+1, where k is the winner's index. A distortion accepted at edge E+k+2 or later sees the new value.
- R4: A winner token leaves the partial distortion of every non-matching unit unchanged.
- R5: The partial distortion saturates at 2^PD_W-1 and never wraps.
- R6: The biased distortion saturates at 2^PD_W-1.
- R7: The shift amount rises by one on every SWEEP_STEP-th `sweep_end` strobe counted since clear. The strobes in between leave the outputs unchanged.
- R8: The shift amount stops at PD_W, where the bias contribution is zero.
- R9: `dist_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the outputs hold steady.
- R10: A `clr` in the cycle after a winner token is presented cancels that token, so no unit is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart of learning state |
| sweep_end | input | 1 | One-cycle strobe at the end of each sweep |
| dist_valid | input | 1 | Input distortion vector valid |
| dist_ready | output | 1 | Input distortion vector accepted when high with valid |
| dist_in | input | N_CW*D_W | Column distortions, column k at bits k*D_W |
| out_valid | output | 1 | Output vector valid |
| out_ready | input | 1 | Downstream accepts output |
| biased_out | output | N_CW*PD_W | Biased distortions, column k at bits k*PD_W |
| raw_out | output | N_CW*D_W | Plain distortions forwarded |
| win_valid | input | 1 | Winner token valid |
| win_id | input | ID_W | Winner codeword index |
| win_dist | input | D_W | Winner's plain distortion |

## Verification
The bench builds the chain with four columns, 8-bit distortions, 10-bit partial distortions and a sweep step of 2. With these values, one winner of distortion 255 adds 195, and a few wins drive the partial distortion to its ceiling. Every shift value up to the cap is reached within about twenty strobes. The bench sweeps each unit index with several distortion values and checks all four columns after each token. This shows both the update delay and that the other units are left untouched.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  // Winner update scale (1 - 1/8)^2 = 49/64 = (32 + 16 + 1) / 64
  localparam int unsigned KEEP_LG = 6;
  localparam int unsigned KEEP_T0 = 5;
  localparam int unsigned KEEP_T1 = 4;
endpackage

// File: rtl/pdb_sweep_tick.sv
module pdb_sweep_tick #(
  parameter int SWEEP_STEP = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sweep_end,
  output logic step
);
  localparam int CNT_W = (SWEEP_STEP > 1) ? $clog2(SWEEP_STEP) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SWEEP_STEP - 1);

  logic [CNT_W-1:0] cnt;

  assign step = sweep_end && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (sweep_end) cnt <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pdb_unit.sv
module pdb_unit
  import pdb_pkg::*;
#(
  parameter int D_W   = 22,
  parameter int PD_W  = 28,
  parameter int ID_W  = 9,
  parameter int SH_W  = 5,
  parameter int MY_ID = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  input  logic            adv,
  input  logic [D_W-1:0]  d_in,
  input  logic            tok_v_i,
  input  logic [ID_W-1:0] tok_id_i,
  input  logic [D_W-1:0]  tok_d_i,
  output logic            tok_v_o,
  output logic [ID_W-1:0] tok_id_o,
  output logic [D_W-1:0]  tok_d_o,
  output logic [PD_W-1:0] dm_o,
  output logic [D_W-1:0]  d_o
);
  localparam int SC_W = D_W + KEEP_LG;
  localparam logic [ID_W-1:0] ID_C   = ID_W'(MY_ID);
  localparam logic [SH_W-1:0] SH_CAP = SH_W'(PD_W);
  localparam logic [PD_W-1:0] PD_MAX = '1;

  logic [PD_W-1:0] pd;
  logic [SH_W-1:0] shamt;
  logic            hit;
  logic [SC_W-1:0] dz, prod;
  logic [PD_W:0]   pd_sum, dm_sum;
  logic [PD_W-1:0] pd_next, dm_next, att;

  assign hit = tok_v_o && (tok_id_o == ID_C);

  always_comb begin
    dz      = SC_W'(tok_d_o);
    prod    = (dz << KEEP_T0) + (dz << KEEP_T1) + dz;
    pd_sum  = {1'b0, pd} + (PD_W+1)'(prod[SC_W-1:KEEP_LG]);
    pd_next = pd_sum[PD_W] ? PD_MAX : pd_sum[PD_W-1:0];
    att     = pd >> shamt;
    dm_sum  = {1'b0, att} + (PD_W+1)'(d_in);
    dm_next = dm_sum[PD_W] ? PD_MAX : dm_sum[PD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_v_o  <= 1'b0;
      tok_id_o <= '0;
      tok_d_o  <= '0;
      pd       <= '0;
      shamt    <= '0;
      dm_o     <= '0;
      d_o      <= '0;
    end else begin
      tok_v_o  <= tok_v_i && !clr;
      tok_id_o <= tok_id_i;
      tok_d_o  <= tok_d_i;
      if (clr) begin
        pd    <= '0;
        shamt <= '0;
      end else begin
        if (hit) pd <= pd_next;
        if (step && shamt != SH_CAP) shamt <= shamt + SH_W'(1);
      end
      if (adv) begin
        d_o  <= d_in;
        dm_o <= dm_next;
      end
    end
  end

  AST_PD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> pd >= $past(pd)); // R5
  AST_PD_OTHER_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hit) |=> $stable(pd)); // R4
  AST_SHAMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(shamt)); // R7
  AST_SHAMT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && shamt == SH_CAP) |=> shamt == SH_CAP); // R8
  AST_BIAS_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    dm_o >= PD_W'(d_o)); // R2
endmodule

// File: rtl/pdb_chain.sv
module pdb_chain #(
  parameter int N_CW       = 4,
  parameter int D_W        = 22,
  parameter int PD_W       = 28,
  parameter int SWEEP_STEP = 16,
  localparam int ID_W      = (N_CW > 1) ? $clog2(N_CW) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 sweep_end,
  input  logic                 dist_valid,
  output logic                 dist_ready,
  input  logic [N_CW*D_W-1:0]  dist_in,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [N_CW*PD_W-1:0] biased_out,
  output logic [N_CW*D_W-1:0]  raw_out,
  input  logic                 win_valid,
  input  logic [ID_W-1:0]      win_id,
  input  logic [D_W-1:0]       win_dist
);
  localparam int SH_W = $clog2(PD_W + 1);

  logic            step, adv;
  logic            tv [N_CW];
  logic [ID_W-1:0] tid [N_CW];
  logic [D_W-1:0]  td [N_CW];

  assign dist_ready = !out_valid || out_ready;
  assign adv        = dist_valid && dist_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (dist_ready) out_valid <= dist_valid;
  end

  pdb_sweep_tick #(.SWEEP_STEP(SWEEP_STEP)) i_tick (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sweep_end(sweep_end), .step(step)
  );

  for (genvar k = 0; k < N_CW; k++) begin : g_col
    logic            vi;
    logic [ID_W-1:0] ii;
    logic [D_W-1:0]  di;
    if (k == 0) begin : g_head
      assign vi = win_valid;
      assign ii = win_id;
      assign di = win_dist;
    end else begin : g_link
      assign vi = tv[k-1];
      assign ii = tid[k-1];
      assign di = td[k-1];
    end
    pdb_unit #(
      .D_W(D_W), .PD_W(PD_W), .ID_W(ID_W), .SH_W(SH_W), .MY_ID(k)
    ) i_unit (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .adv(adv),
      .d_in(dist_in[k*D_W +: D_W]),
      .tok_v_i(vi), .tok_id_i(ii), .tok_d_i(di),
      .tok_v_o(tv[k]), .tok_id_o(tid[k]), .tok_d_o(td[k]),
      .dm_o(biased_out[k*PD_W +: PD_W]), .d_o(raw_out[k*D_W +: D_W])
    );
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(biased_out) && $stable(raw_out)); // R9
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid) |-> dist_ready); // R9
endmodule

// File: tb/test_pdb_chain.sv
module test_pdb_chain;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int PW = 10;
  localparam int ST = 2;
  localparam int PMAX = (1 << PW) - 1;

  logic clk = 0, rst_n = 0, clr = 0, sweep_end = 0;
  logic dist_valid = 0, out_ready = 1, win_valid = 0;
  logic dist_ready, out_valid;
  logic [N*DW-1:0] dist_in = '0;
  logic [N*PW-1:0] biased_out;
  logic [N*DW-1:0] raw_out;
  logic [1:0] win_id = '0;
  logic [DW-1:0] win_dist = '0;

  int pdm [N];
  int shm = 0, swc = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pdb_chain #(.N_CW(N), .D_W(DW), .PD_W(PW), .SWEEP_STEP(ST)) i_pdb_chain (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sweep_end(sweep_end),
    .dist_valid(dist_valid), .dist_ready(dist_ready), .dist_in(dist_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .biased_out(biased_out), .raw_out(raw_out),
    .win_valid(win_valid), .win_id(win_id), .win_dist(win_dist));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_dm(int d, int p);
    int s = d + (p >> shm);
    return (s > PMAX) ? PMAX : s;
  endfunction

  task automatic push(input int s0, input string tag);
    int v [N];
    for (int k = 0; k < N; k++) begin
      v[k] = (s0 + 53 * k) % 256;
      dist_in[k*DW +: DW] = DW'(v[k]);
    end
    @(negedge clk); dist_valid = 1;
    @(negedge clk); dist_valid = 0;
    chk({tag, " R9 out_valid"}, int'(out_valid), 1);
    for (int k = 0; k < N; k++) begin
      chk({tag, " R2 raw"}, int'(raw_out[k*DW +: DW]), v[k]);
      chk({tag, " biased"}, int'(biased_out[k*PW +: PW]), exp_dm(v[k], pdm[k]));
    end
  endtask

  task automatic win(input int id, input int d);
    @(negedge clk); win_valid = 1; win_id = 2'(id); win_dist = DW'(d);
    @(negedge clk); win_valid = 0;
    repeat (N + 2) @(negedge clk);
    pdm[id] = pdm[id] + (d * 49) / 64;
    if (pdm[id] > PMAX) pdm[id] = PMAX;
  endtask

  task automatic sweep();
    @(negedge clk); sweep_end = 1;
    @(negedge clk); sweep_end = 0;
    swc++;
    if (swc == ST) begin
      swc = 0;
      if (shm < PW) shm++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < N; k++) pdm[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R9 ready when empty", int'(dist_ready), 1);
    push(200, "R1 reset");
    push(255, "R1 reset max");

    // R3 R4: each unit index with several distortions
    for (int id = 0; id < N; id++) begin
      for (int j = 0; j < 3; j++) begin
        win(id, (37 * j + 19 * id + 5) % 256);
        push(11 * j + 3 * id, "R3 R4 update");
      end
    end

    // R5 R6: drive unit 2 to its ceiling
    for (int j = 0; j < 6; j++) win(2, 255);
    chk("R5 model saturated", pdm[2], PMAX);
    push(255 - 2 * 53 + 256, "R5 R6 saturate");

    // R7 R8: shift steps and cap
    sweep();
    push(40, "R7 between strobes");
    for (int j = 0; j < 2 * PW + 4; j++) begin
      sweep();
      if (swc == 0) push(9 * j, "R7 R8 shift");
    end
    chk("R8 model cap", shm, PW);
    push(77, "R8 shift capped");

    // R9: back-pressure
    @(negedge clk);
    out_ready = 0; dist_valid = 1;
    for (int k = 0; k < N; k++) dist_in[k*DW +: DW] = DW'(10 + k);
    @(negedge clk);
    for (int k = 0; k < N; k++) dist_in[k*DW +: DW] = DW'(100 + k);
    @(negedge clk);
    chk("R9 ready low when stalled", int'(dist_ready), 0);
    chk("R9 valid held", int'(out_valid), 1);
    for (int k = 0; k < N; k++)
      chk("R9 raw held", int'(raw_out[k*DW +: DW]), 10 + k);
    out_ready = 1;
    @(negedge clk); dist_valid = 0;
    for (int k = 0; k < N; k++)
      chk("R9 next accepted", int'(raw_out[k*DW +: DW]), 100 + k);

    // R10 R1: clear right behind a token
    @(negedge clk); win_valid = 1; win_id = 2'd1; win_dist = 8'd200;
    @(negedge clk); win_valid = 0; clr = 1;
    @(negedge clk); clr = 0;
    repeat (N + 2) @(negedge clk);
    for (int k = 0; k < N; k++) pdm[k] = 0;
    shm = 0; swc = 0;
    push(123, "R10 R1 clear");
    sweep();
    push(50, "R7 after clear");
    sweep();
    win(3, 128);
    push(66, "R7 R3 after clear");

    finish_run();
  end
endmodule